// File: doc/BRIEF.md
# Execute-Stage Integer ALU

This block is the arithmetic unit of the execute stage of a five-stage load/store pipeline. It is purely combinational: every cycle it takes the two operand values latched for the execute stage together with the full 32-bit instruction word that travels alongside them, works out from that word which operation to perform, and returns a 32-bit result in the same cycle. The surrounding pipeline is responsible for choosing what feeds the B operand (a register value or a sign-extended offset) and for registering the result into the memory stage.

Register-format instructions (primary opcode zero) pick one of five operations through their function code: add, subtract, logical shift left, logical shift right and bitwise inversion. The two shifts and the inversion act on the B operand only, and the shift distance is taken from a 5-bit field inside the instruction. Load and store instructions use the unit only to form a memory address as A plus B. Anything else, including the all-zero no-operation word, yields a zero result, so a bubble never produces a stray value downstream.

Top module: `exu_alu`

## Requirements
- R1: With instruction bits 31:26 equal to 000000 and bits 5:0 equal to 100000, result equals (A + B) modulo 2^32.
- R2: With bits 31:26 equal to 000000 and bits 5:0 equal to 100010, result equals (A - B) modulo 2^32, wrapping below zero.
- R3: With bits 31:26 equal to 000000 and bits 5:0 equal to 000001, result equals B shifted left by the count in instruction bits 10:6, zeros entering at the low end.
- R4: With bits 31:26 equal to 000000 and bits 5:0 equal to 000010, result equals B shifted right by the count in bits 10:6 with zero fill; a count of 0 returns B unchanged.
- R5: With bits 31:26 equal to 000000 and bits 5:0 equal to 000100, result equals the bitwise inverse of B.
- R6: For the shift and inversion operations of R3, R4 and R5, the value of A has no effect on the result.
- R7: With bits 31:26 equal to 100011 (load) or 101011 (store), result equals (A + B) modulo 2^32 whatever bits 25:0 hold.
- R8: The all-zero instruction word gives a result of zero for any A and B.
- R9: Any other opcode, or opcode 000000 with a function code not listed in R1 to R5, gives a result of zero.
- R10: The result follows a change of A, B or the instruction within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (base register value) |
| opnd_b | input | 32 | Second operand (register value or extended offset) |
| instr | input | 32 | Instruction word held in the execute stage |
| result | output | 32 | Operation result |

## Verification
Because the unit holds no state, a fault in its decode or datapath shows on the result port in the very cycle the faulty instruction is presented, and disappears when the next word arrives. A wrong decode appears as a plausible-looking value from a neighbouring operation (a sum where a difference was due, a left shift in place of a right one), so each operation is driven with operands whose results differ across every alternative. A mis-wired shifter stage only shows for counts that set that bit of the shift field, so counts of 0, 1, 16 and 31 and patterns with the top bit set are used.

// File: rtl/exu_alu_pkg.sv
package exu_alu_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned SHAMT_W = 5;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_SLL = 6'b000001;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_INV = 6'b000100;

  typedef enum logic [2:0] {
    ALU_ZERO = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_SLL  = 3'd3,
    ALU_SRL  = 3'd4,
    ALU_INV  = 3'd5
  } alu_op_e;

  typedef struct packed {
    alu_op_e              op;
    logic [SHAMT_W-1:0]   shamt;
  } alu_ctl_t;

  // Two's complement add or subtract on one adder; carry-out dropped.
  function automatic logic [XLEN-1:0] addsub(input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b,
                                            input logic            sub);
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] cin;
    b_eff = sub ? ~b : b;
    cin   = {{(XLEN-1){1'b0}}, sub};
    return a + b_eff + cin;
  endfunction

endpackage

// File: rtl/exu_alu_decode.sv
module exu_alu_decode
  import exu_alu_pkg::*;
(
  input  logic [5:0]         opcode,
  input  logic [5:0]         funct,
  input  logic [SHAMT_W-1:0] shamt_fld,
  output alu_ctl_t           ctl,
  output logic [4:0]         sel_vec
);

  alu_op_e op;

  always_comb begin
    op = ALU_ZERO;
    if (opcode == OPC_REG) begin
      unique case (funct)
        FN_ADD:  op = ALU_ADD;
        FN_SUB:  op = ALU_SUB;
        FN_SLL:  op = ALU_SLL;
        FN_SRL:  op = ALU_SRL;
        FN_INV:  op = ALU_INV;
        default: op = ALU_ZERO;
      endcase
    end else if ((opcode == OPC_LOAD) || (opcode == OPC_STORE)) begin
      op = ALU_ADD;
    end
  end

  assign ctl.op    = op;
  assign ctl.shamt = shamt_fld;

  // Named select lines, one per operation, for the checks below.
  assign sel_vec = {op == ALU_INV, op == ALU_SRL, op == ALU_SLL,
                    op == ALU_SUB, op == ALU_ADD};

  // R9: at most one operation selected, none for unknown codes
  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      one_op_chk: assert ($onehot0(sel_vec));
      if ((opcode != OPC_REG) && (opcode != OPC_LOAD) && (opcode != OPC_STORE))
        unk_opc_chk: assert (sel_vec == 5'b0);
    end
  end

endmodule

// File: rtl/exu_alu_adder.sv
module exu_alu_adder
  import exu_alu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum
);

  logic [W-1:0] b_eff;
  logic [W-1:0] cin;

  assign b_eff = sub ? ~b : b;
  assign cin   = {{(W-1){1'b0}}, sub};
  assign sum   = a + b_eff + cin;

  // R2: a difference added back to B recovers A
  always_comb begin
    if (!$isunknown({a, b, sub}) && sub)
      sub_inv_chk: assert ((sum + b) == a);
  end

endmodule

// File: rtl/exu_alu_shift.sv
module exu_alu_shift
  import exu_alu_pkg::*;
#(
  parameter int unsigned W   = XLEN,
  parameter int unsigned AMT = SHAMT_W
) (
  input  logic [W-1:0]   din,
  input  logic [AMT-1:0] amt,
  input  logic           left,
  output logic [W-1:0]   dout
);

  logic [W-1:0] stg [0:AMT];

  assign stg[0] = din;

  generate
    for (genvar k = 0; k < AMT; k++) begin : g_stage
      localparam int unsigned DIST = 1 << k;
      logic [W-1:0] moved;
      assign moved      = left ? (stg[k] << DIST) : (stg[k] >> DIST);
      assign stg[k + 1] = amt[k] ? moved : stg[k];
    end
  endgenerate

  assign dout = stg[AMT];

  // R4: zero count is a pass-through
  always_comb begin
    if (!$isunknown({din, amt, left}) && (amt == '0))
      zero_amt_chk: assert (dout == din);
  end

  // R3: left shift never leaves ones below the count
  always_comb begin
    if (!$isunknown({din, amt, left}) && left)
      sll_fill_chk: assert ((dout & ((W'(1) << amt) - W'(1))) == '0);
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_alu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [31:0]   instr,
  output logic [W-1:0]  result
);

  alu_ctl_t   ctl;
  logic [4:0] sel_vec;
  logic [W-1:0] sum_w;
  logic [W-1:0] shf_w;
  logic         is_sub;
  logic         is_left;

  exu_alu_decode u_dec (
    .opcode    (instr[31:26]),
    .funct     (instr[5:0]),
    .shamt_fld (instr[10:6]),
    .ctl       (ctl),
    .sel_vec   (sel_vec)
  );

  assign is_sub  = (ctl.op == ALU_SUB);
  assign is_left = (ctl.op == ALU_SLL);

  exu_alu_adder #(.W(W)) u_add (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (is_sub),
    .sum (sum_w)
  );

  exu_alu_shift #(.W(W), .AMT(SHAMT_W)) u_shf (
    .din  (opnd_b),
    .amt  (ctl.shamt),
    .left (is_left),
    .dout (shf_w)
  );

  always_comb begin
    unique case (ctl.op)
      ALU_ADD, ALU_SUB: result = sum_w;
      ALU_SLL, ALU_SRL: result = shf_w;
      ALU_INV:          result = ~opnd_b;
      default:          result = '0;
    endcase
  end

  // R8: the empty instruction word produces nothing
  always_comb begin
    if (!$isunknown({instr, opnd_a, opnd_b}) && (instr == 32'h0))
      nop_zero_chk: assert (result == '0);
  end

  // R5: inverted result and B together cover every bit exactly once
  always_comb begin
    if (!$isunknown({instr, opnd_b}) && sel_vec[4])
      inv_chk: assert ((result ^ opnd_b) == '1);
  end

  // R7: address formation matches the shared adder function
  always_comb begin
    if (!$isunknown({instr, opnd_a, opnd_b}) &&
        ((instr[31:26] == OPC_LOAD) || (instr[31:26] == OPC_STORE)))
      addr_chk: assert (result == addsub(opnd_a, opnd_b, 1'b0));
  end

endmodule

// File: tb/tb_exu_alu.sv
module tb_exu_alu;

  logic        clk = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] instr  = '0;
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  exu_alu dut (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .instr  (instr),
    .result (result)
  );

  function automatic logic [31:0] rtype(input logic [5:0] fn, input logic [4:0] sh);
    return {6'b000000, 5'd7, 5'd9, 5'd11, sh, fn};
  endfunction

  function automatic logic [31:0] ref_sll(input logic [31:0] v, input int s);
    logic [31:0] r;
    r = v;
    for (int i = 0; i < s; i++) r = {r[30:0], 1'b0};
    return r;
  endfunction

  function automatic logic [31:0] ref_srl(input logic [31:0] v, input int s);
    logic [31:0] r;
    r = v;
    for (int i = 0; i < s; i++) r = {1'b0, r[31:1]};
    return r;
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [31:0] i);
    @(negedge clk);
    opnd_a = a; opnd_b = b; instr = i;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    n_cmp++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s: instr=%h got %h expected %h", req, instr, result, exp);
    end
  endtask

  task automatic t_idle;
    apply(32'h0, 32'h0, 32'h0);
    check("R8 idle", 32'h0);
  endtask

  task automatic t_add;
    apply(32'h1234_5678, 32'h0F0F_0F0F, rtype(6'b100000, 5'd3));
    check("R1", 32'h2143_6587);
    apply(32'hFFFF_FFFF, 32'h0000_0002, rtype(6'b100000, 5'd0));
    check("R1 wrap", 32'h0000_0001);
  endtask

  task automatic t_sub;
    apply(32'h0000_0100, 32'h0000_0001, rtype(6'b100010, 5'd0));
    check("R2", 32'h0000_00FF);
    apply(32'h0000_0000, 32'h0000_0001, rtype(6'b100010, 5'd9));
    check("R2 wrap", 32'hFFFF_FFFF);
  endtask

  task automatic t_sll;
    int cnt [4] = '{0, 1, 16, 31};
    foreach (cnt[k]) begin
      apply(32'hDEAD_BEEF, 32'h8000_0001 | 32'h00F0_0000, rtype(6'b000001, cnt[k][4:0]));
      check("R3", ref_sll(32'h80F0_0001, cnt[k]));
    end
  endtask

  task automatic t_srl;
    int cnt [4] = '{0, 1, 16, 31};
    foreach (cnt[k]) begin
      apply(32'h1111_1111, 32'h8765_4321, rtype(6'b000010, cnt[k][4:0]));
      check(cnt[k] == 0 ? "R4 zero count" : "R4", ref_srl(32'h8765_4321, cnt[k]));
    end
  endtask

  task automatic t_inv;
    apply(32'h0000_0000, 32'h0F0F_00FF, rtype(6'b000100, 5'd0));
    check("R5", 32'hF0F0_FF00);
  endtask

  task automatic t_a_ignored;
    apply(32'h0, 32'h0000_00C3, rtype(6'b000001, 5'd4));
    check("R6 sll a=0", 32'h0000_0C30);
    apply(32'hFFFF_FFFF, 32'h0000_00C3, rtype(6'b000001, 5'd4));
    check("R6 sll a=ones", 32'h0000_0C30);
    apply(32'hA5A5_A5A5, 32'h0000_00C3, rtype(6'b000010, 5'd4));
    check("R6 srl", 32'h0000_000C);
    apply(32'h5A5A_5A5A, 32'h0000_FFFF, rtype(6'b000100, 5'd2));
    check("R6 inv", 32'hFFFF_0000);
  endtask

  task automatic t_mem;
    apply(32'h0000_1000, 32'hFFFF_FFFC, {6'b100011, 26'h3FF_FFFF});
    check("R7 load", 32'h0000_0FFC);
    apply(32'h0000_2000, 32'h0000_0008, {6'b101011, 26'h000_0022});
    check("R7 store", 32'h0000_2008);
  endtask

  task automatic t_nop;
    apply(32'hCAFE_F00D, 32'h1357_9BDF, 32'h0);
    check("R8 nop", 32'h0);
  endtask

  task automatic t_other;
    apply(32'h1, 32'h2, rtype(6'b100100, 5'd0));
    check("R9 funct", 32'h0);
    apply(32'h1, 32'h2, rtype(6'b000011, 5'd1));
    check("R9 funct mix", 32'h0);
    apply(32'h1, 32'h2, {6'b001000, 26'h000_0020});
    check("R9 opcode", 32'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    opnd_a = 32'd10; opnd_b = 32'd3; instr = rtype(6'b100000, 5'd0);
    #1 check("R10 add", 32'd13);
    instr = rtype(6'b100010, 5'd0);
    #1 check("R10 sub", 32'd7);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_add();
    t_sub();
    t_sll();
    t_srl();
    t_inv();
    t_a_ignored();
    t_mem();
    t_nop();
    t_other();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule